// File: doc/BRIEF.md
# Change-Triggered Interrupt Aggregator with Message Write

This block gathers a set of interrupt request lines into a single interrupt toward a processor. Each line is synchronized and watched for changes in either direction. A change on an enabled line is latched into a read-clear request register. The block then signals the processor by issuing one write of a programmed data word to a programmed address on a valid/ready request port. A second read-clear register latches changes on every implemented line, whether it is enabled or not. A live level register shows the present state of every line.

Software enables lines through a mask. A line that is already high when it is enabled raises nothing by itself, because only changes are captured. Software uses the live level register to find such a line and service it. At most one outgoing message exists at a time. Changes that arrive while a message waits for the receiver are folded into that message.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, the mask, request and change registers read zero and `msg_valid` is low.
- R2: A change in either direction on an implemented line whose mask bit is 1 sets that line's bit in the request register, at byte offset 0x08. A change on a line whose mask bit is 0 leaves the request register untouched.
- R3: A change on any implemented line, whatever the mask, sets that line's bit in the change register at byte offset 0x0C.
- R4: The level register at byte offset 0x10 shows the synchronized present level of every implemented line, independent of the mask. Reading the change register does not alter the level register.
- R5: A read of the request register or the change register returns the latched bits and clears them. A change captured in the same cycle as that read remains set after the clear.
- R6: Every change on an enabled line starts a message. `msg_addr` is the target word at byte offset 0x00 with its low DATA_BITS (default 5) bits forced to zero. `msg_data` is those low DATA_BITS bits, zero-extended.
- R7: A line that is already high when its mask bit is written to 1 produces neither a request bit nor a message.
- R8: Once raised, `msg_valid` stays high and `msg_addr` and `msg_data` stay stable until `msg_ready` is seen high. Further enabled changes during that wait add no second message.
- R9: Only the bits in IMPL_MASK (default 0x5FF, so bit 9 is absent) exist. Unimplemented bits read 0 in the mask, request, change and level registers and never start a message.
- R10: Registers are read and written at word-aligned byte offsets: target 0x00, mask 0x04, request 0x08, change 0x0C, level 0x10. `reg_rdata` updates on the clock edge that samples `reg_rd`. Other or unaligned offsets read 0 and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES (11) | Asynchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the request and change registers) |
| reg_addr | input | REG_AW (5) | Register byte offset |
| reg_wdata | input | REG_DW (32) | Register write data |
| reg_rdata | output | REG_DW (32) | Registered read data |
| msg_valid | output | 1 | Outgoing interrupt write is valid |
| msg_ready | input | 1 | Receiver accepts the outgoing write |
| msg_addr | output | REG_DW (32) | Address of the outgoing write |
| msg_data | output | REG_DW (32) | Data of the outgoing write |

## Verification
The checker watches the request port on every cycle. It checks that a raised message and its payload hold until accepted, that a message starts only after an enabled change with a nonzero mask, that no message exists right after reset, and that reads of the request register never show an unimplemented bit. The bench scenarios cover the effects that need a sequence of accesses. These are the masked versus unmasked capture, the read that coincides with a change, the line already high when enabled, the merging of several changes into one message, and the level register surviving a change-register read.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef enum logic [2:0] {
    SEL_TARGET = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_REQ    = 3'd2,
    SEL_CHG    = 3'd3,
    SEL_LEVEL  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] change
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      level_d <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      level_d <= stg[STAGES-1];
    end
  end

  assign level  = stg[STAGES-1];
  assign change = stg[STAGES-1] ^ level_d;
endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst)      bits <= '0;
    else if (clr) bits <= set_vec;
    else          bits <= bits | set_vec;
  end
endmodule

// File: rtl/irqagg_msg.sv
module irqagg_msg #(
  parameter int DW        = 32,
  parameter int DATA_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [DW-1:0] target,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam logic [DW-1:0] LOW_MASK = (DW'(1) << DATA_BITS) - DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (fire && (!valid || ready)) begin
      valid <= 1'b1;
      addr  <= target & ~LOW_MASK;
      data  <= target & LOW_MASK;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int              NUM_LINES = 11,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 11'h5FF,
  parameter int              SYNC_STAGES = 2,
  parameter int              REG_AW    = 5,
  parameter int              REG_DW    = 32,
  parameter int              DATA_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [REG_DW-1:0]    msg_addr,
  output logic [REG_DW-1:0]    msg_data
);
  localparam int SEL_W = REG_AW - 2;
  localparam int PAD_W = REG_DW - NUM_LINES;

  logic [NUM_LINES-1:0] level, change, req_bits, chg_bits, mask_q;
  logic [NUM_LINES-1:0] req_set, chg_set;
  logic [REG_DW-1:0]    target_q;
  logic [SEL_W-1:0]     sel;
  logic                 aligned, req_clr, chg_clr, fire;

  assign sel     = reg_addr[REG_AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  irqagg_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(irq_in), .level(level), .change(change)
  );

  assign chg_set = change & IMPL_MASK;
  assign req_set = chg_set & mask_q;
  assign req_clr = reg_rd && aligned && (sel == SEL_W'(SEL_REQ));
  assign chg_clr = reg_rd && aligned && (sel == SEL_W'(SEL_CHG));
  assign fire    = |req_set;

  irqagg_capture #(.W(NUM_LINES)) u_req (
    .clk(clk), .rst(rst), .set_vec(req_set), .clr(req_clr), .bits(req_bits)
  );

  irqagg_capture #(.W(NUM_LINES)) u_chg (
    .clk(clk), .rst(rst), .set_vec(chg_set), .clr(chg_clr), .bits(chg_bits)
  );

  irqagg_msg #(.DW(REG_DW), .DATA_BITS(DATA_BITS)) u_msg (
    .clk(clk), .rst(rst), .fire(fire), .target(target_q), .ready(msg_ready),
    .valid(msg_valid), .addr(msg_addr), .data(msg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      target_q <= '0;
    end else if (reg_wr && aligned) begin
      if (sel == SEL_W'(SEL_MASK))   mask_q   <= reg_wdata[NUM_LINES-1:0] & IMPL_MASK;
      if (sel == SEL_W'(SEL_TARGET)) target_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (!aligned) reg_rdata <= '0;
      else begin
        case (sel)
          SEL_W'(SEL_TARGET): reg_rdata <= target_q;
          SEL_W'(SEL_MASK):   reg_rdata <= {{PAD_W{1'b0}}, mask_q};
          SEL_W'(SEL_REQ):    reg_rdata <= {{PAD_W{1'b0}}, req_bits};
          SEL_W'(SEL_CHG):    reg_rdata <= {{PAD_W{1'b0}}, chg_bits};
          SEL_W'(SEL_LEVEL):  reg_rdata <= {{PAD_W{1'b0}}, level & IMPL_MASK};
          default:            reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int NUM_LINES = 11,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 11'h5FF,
  parameter int REG_AW = 5,
  parameter int REG_DW = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [REG_DW-1:0]    msg_addr,
  input logic [REG_DW-1:0]    msg_data,
  input logic                 fire,
  input logic [NUM_LINES-1:0] mask_q,
  input logic                 reg_rd,
  input logic [REG_AW-1:0]    reg_addr,
  input logic [REG_DW-1:0]    reg_rdata
);
  localparam logic [REG_DW-1:0] IMPL_EXT = REG_DW'(IMPL_MASK);

  // R8: a waiting message stays raised
  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid);

  // R8: payload stable while waiting
  assert_stable_payload_R8: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> $stable(msg_addr) && $stable(msg_data));

  // R6: a message begins only after an enabled change
  assert_rise_needs_change_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(fire));

  // R7: no message can begin while the mask was empty
  assert_rise_needs_mask_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> ($past(mask_q) != '0));

  // R1: nothing outgoing right after reset
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid);

  // R9: request reads never show unimplemented bits
  assert_no_ghost_bits_R9: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd) && ($past(reg_addr) == REG_AW'(8)) |-> ((reg_rdata & ~IMPL_EXT) == '0));
endmodule

bind irq_aggregator irqagg_checker #(
  .NUM_LINES(NUM_LINES), .IMPL_MASK(IMPL_MASK), .REG_AW(REG_AW), .REG_DW(REG_DW)
) u_irqagg_checker (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .fire(fire), .mask_q(mask_q),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NL = 11;
  localparam logic [10:0] IMPL = 11'h5FF;
  localparam logic [4:0] A_TGT = 5'h00, A_MASK = 5'h04, A_REQ = 5'h08,
                         A_CHG = 5'h0C, A_LVL = 5'h10;

  localparam int NV = 6;
  localparam logic [10:0] V_LINES [NV] = '{11'h001, 11'h401, 11'h000, 11'h3C0, 11'h200, 11'h23F};
  localparam logic [10:0] V_MASK  [NV] = '{11'h7FF, 11'h400, 11'h001, 11'h0F0, 11'h7FF, 11'h000};

  logic clk = 1'b0, rst = 1'b1;
  logic [NL-1:0] irq_in = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, msg_ready = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, msg_addr, msg_data;
  logic msg_valid;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic accept();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, tgt, exp_addr, exp_data;
    logic [10:0] prev, diff, mval;
    cycles(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 valid", {31'd0, msg_valid}, 32'd0);
    rd(A_MASK, d); check("R1 mask", d, 32'd0);
    rd(A_REQ, d);  check("R1 request", d, 32'd0);
    rd(A_CHG, d);  check("R1 change", d, 32'd0);

    // Vector walk: R2 R3 R4 R6 R9 R10
    prev = '0;
    for (int i = 0; i < NV; i++) begin
      tgt = 32'h8000_1200 | 32'(i * 7 + 3);
      exp_addr = tgt & ~32'h1F;
      exp_data = tgt & 32'h1F;
      wr(A_TGT, tgt);
      rd(A_TGT, d); check("R10 target readback", d, tgt);
      wr(A_MASK, {21'd0, V_MASK[i]});
      rd(A_MASK, d); check("R9 mask readback", d, {21'd0, V_MASK[i] & IMPL});
      rd(A_REQ, d);
      rd(A_CHG, d);
      irq_in = V_LINES[i];
      cycles(6);
      diff = (prev ^ V_LINES[i]) & IMPL;
      mval = V_MASK[i] & IMPL;
      check("R6 valid", {31'd0, msg_valid}, {31'd0, |(diff & mval)});
      if (|(diff & mval)) begin
        check("R6 addr", msg_addr, exp_addr);
        check("R6 data", msg_data, exp_data);
        accept();
        check("R8 valid drops after accept", {31'd0, msg_valid}, 32'd0);
      end
      rd(A_REQ, d); check("R2 request", d, {21'd0, diff & mval});
      rd(A_CHG, d); check("R3 change", d, {21'd0, diff});
      rd(A_LVL, d); check("R4 level", d, {21'd0, V_LINES[i] & IMPL});
      prev = V_LINES[i];
    end

    // R5 + R4: read-clear, level survives change read
    rd(A_CHG, d); check("R5 change cleared", d, 32'd0);
    rd(A_LVL, d); check("R4 level after change read", d, {21'd0, prev & IMPL});
    rd(A_REQ, d); check("R5 request cleared", d, 32'd0);

    // R10 unaligned / unmapped offsets
    rd(5'h14, d); check("R10 unmapped", d, 32'd0);
    rd(5'h05, d); check("R10 unaligned", d, 32'd0);

    // R7: line already high when enabled
    irq_in = '0;
    wr(A_MASK, 32'd0);
    cycles(6);
    rd(A_REQ, d); rd(A_CHG, d);
    irq_in = 11'h004;
    cycles(6);
    rd(A_REQ, d); rd(A_CHG, d);
    wr(A_MASK, 32'h004);
    cycles(6);
    check("R7 no message", {31'd0, msg_valid}, 32'd0);
    rd(A_REQ, d); check("R7 no request", d, 32'd0);
    rd(A_LVL, d); check("R7 level shows line", d, 32'h004);

    // R5: change captured in the same cycle as the read
    wr(A_MASK, 32'h7FF);
    irq_in = 11'h005;
    @(negedge clk);
    @(negedge clk);
    rd(A_REQ, d); check("R5 coincident read old value", d, 32'd0);
    rd(A_REQ, d); check("R5 coincident bit survives", d, 32'h001);
    check("R6 coincident message", {31'd0, msg_valid}, 32'd1);
    accept();

    // R8: merge while waiting
    irq_in = 11'h004;
    cycles(6);
    check("R8 first raised", {31'd0, msg_valid}, 32'd1);
    irq_in = 11'h006;
    cycles(6);
    check("R8 still waiting", {31'd0, msg_valid}, 32'd1);
    accept();
    check("R8 merged into one", {31'd0, msg_valid}, 32'd0);
    rd(A_REQ, d); check("R8 both captured", d, 32'h003);

    // R9: unimplemented line never triggers
    rd(A_CHG, d);
    irq_in = 11'h206;
    cycles(6);
    check("R9 no message", {31'd0, msg_valid}, 32'd0);
    rd(A_CHG, d); check("R9 no change bit", d, 32'd0);
    rd(A_LVL, d); check("R9 level hides bit", d, 32'h006);

    finish_run();
  end
endmodule